// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This unit takes two 32-bit IEEE-754 single-precision operands and an operation code. It returns either a one-bit comparison result or a 32-bit minimum/maximum value, along with a 5-bit exception flag vector. Each operation runs in one pass through combinational logic followed by a single register stage. A result therefore appears on the cycle after the input was presented with `in_valid` high. Between valid inputs the registered outputs keep their last value.

The comparisons order values by sign and magnitude, and treat the two signed zeros as equal. Any comparison that involves a NaN returns false. Each comparison comes in a signaling form and a quiet form, and the two forms differ only in when the invalid flag is raised. Min and max follow the usual NaN-suppressing rule: a single NaN operand is ignored, and only a pair of NaNs yields the canonical NaN. Min and max also pick the correctly signed zero no matter which operand holds which zero.

Top module: `fpcmp_unit`

## Requirements
- R1: The flag vector puts invalid in bit 4, divide-by-zero in bit 3, overflow in bit 2, underflow in bit 1 and inexact in bit 0. Only invalid can ever be set by this unit; bits 3..0 always read zero.
- R2: Operation 0 (equal) returns 1 when the two bit patterns are identical or both operands are zeros of either sign, and 0 when either operand is a NaN. It raises invalid only when an operand is a signaling NaN (exponent all ones, mantissa MSB 0, mantissa nonzero).
- R3: Operations 1 (less-than) and 2 (less-or-equal) are the signaling forms. They raise invalid when either operand is any NaN, and they return 0 in that case.
- R4: Operations 3 (quiet less-than) and 4 (quiet less-or-equal) return the same result as operations 1 and 2, but raise invalid only for a signaling NaN operand.
- R5: For two positive values, ordering compares exponent first and then mantissa, both as unsigned numbers. For two negative values the ordering is reversed. A negative value is less than a positive value.
- R6: -0 and +0 compare equal: equal and less-or-equal return 1 and less-than returns 0, whatever the operand order.
- R7: Operations 5 (min) and 6 (max) return the lesser and the greater operand respectively. If exactly one operand is a NaN, the other operand is returned unchanged. If both operands are NaN, the result is the canonical NaN 0x7FC00000.
- R8: Min of -0 and +0 returns -0 (0x80000000) and max returns +0 (0x00000000), in either operand order.
- R9: Min and max raise invalid only when an operand is a signaling NaN.
- R10: Outputs update on the clock edge that samples `in_valid` high, and `out_valid` is high for exactly that one following cycle. While `in_valid` is low, `out_bool`, `out_val` and `out_flags` hold their values.
- R11: During reset, all outputs are zero.
- R12: For compare operations (0..4), `out_val` is zero. For min/max (5, 6), `out_bool` is zero. Operation code 7 is reserved and produces all-zero results and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op | input | 3 | Operation code (see R2, R3, R4, R7, R12) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_bool | output | 1 | Comparison result |
| out_val | output | 32 | Min/max result |
| out_flags | output | 5 | Exception flags, invalid in bit 4 |

## Verification
The bench targets the signed-zero cases for every operation. A design that reused a plain sign test would report -0 < +0, and a design that chose between equal operands by order would return the wrong zero from min or max. NaN handling gets the same treatment. Quiet NaNs go through equal and the quiet compares, where a wrong design would raise invalid. Signaling NaNs go through min and max, where a wrong design would fail to raise it. One-NaN and two-NaN pairs show whether a design propagates the NaN instead of suppressing it, or returns the NaN payload instead of the canonical value. Negative-operand ordering exposes an unreversed magnitude compare. Idle cycles after a result expose outputs that do not hold.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [2:0] {
        OP_EQ   = 3'd0,
        OP_LT   = 3'd1,
        OP_LE   = 3'd2,
        OP_LTQ  = 3'd3,
        OP_LEQ  = 3'd4,
        OP_MIN  = 3'd5,
        OP_MAX  = 3'd6,
        OP_RSVD = 3'd7
    } fpcmp_op_e;

    localparam int FLAG_W   = 5;
    localparam int FLAG_INV = 4;

    typedef struct packed {
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] x,
    output fp_class_t    cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        exp_f       = x[W-2 -: EXP_W];
        man_f       = x[MAN_W-1:0];
        cls.is_zero = (exp_f == '0) && (man_f == '0);
        cls.is_nan  = (exp_f == '1) && (man_f != '0);
        cls.is_snan = (exp_f == '1) && (man_f != '0) && !man_f[MAN_W-1];
    end

    // R2: a signaling NaN is always also a NaN and never a zero
    always_comb begin
        assert_snan_is_nan_R2: assert (!cls.is_snan || (cls.is_nan && !cls.is_zero));
    end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  fp_class_t    cls_a,
    input  fp_class_t    cls_b,
    output logic         lt,
    output logic         eq,
    output logic         le
);
    logic         sgn_a;
    logic         sgn_b;
    logic [W-2:0] mag_a;
    logic [W-2:0] mag_b;
    logic         zeros;

    always_comb begin
        sgn_a = a[W-1];
        sgn_b = b[W-1];
        mag_a = a[W-2:0];
        mag_b = b[W-2:0];
        zeros = cls_a.is_zero && cls_b.is_zero;
        eq    = (a == b) || zeros;
        if (zeros)
            lt = 1'b0;
        else if (sgn_a != sgn_b)
            lt = sgn_a;
        else if (sgn_a)
            lt = mag_b < mag_a;
        else
            lt = mag_a < mag_b;
        le = lt || eq;
    end

    // R6: strict and equal orderings never both hold
    always_comb begin
        assert_lt_eq_exclusive_R6: assert (!(lt && eq));
    end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic              out_valid,
    output logic              out_bool,
    output logic [W-1:0]      out_val,
    output logic [FLAG_W-1:0] out_flags
);
    localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic              res_bool;
        logic [W-1:0]      res_val;
        logic [FLAG_W-1:0] flags;
    } result_t;

    result_t    res_d;
    result_t    res_q;
    fpcmp_op_e  op_e;
    fp_class_t  cls [2];
    logic [W-1:0] opnd [2];
    logic       ord_lt;
    logic       ord_eq;
    logic       ord_le;
    logic       any_nan;
    logic       any_snan;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;
    assign op_e    = fpcmp_op_e'(op);

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .x   (opnd[gi]),
            .cls (cls[gi])
        );
    end

    fpcmp_order #(.W(W)) u_order (
        .a     (opnd_a),
        .b     (opnd_b),
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .lt    (ord_lt),
        .eq    (ord_eq),
        .le    (ord_le)
    );

    always_comb begin
        any_nan  = cls[0].is_nan  || cls[1].is_nan;
        any_snan = cls[0].is_snan || cls[1].is_snan;
        res_d    = res_q;
        res_d.valid = 1'b0;
        if (in_valid) begin
            res_d = '0;
            res_d.valid = 1'b1;
            unique case (op_e)
                OP_EQ: begin
                    res_d.res_bool        = ord_eq && !any_nan;
                    res_d.flags[FLAG_INV] = any_snan;
                end
                OP_LT: begin
                    res_d.res_bool        = ord_lt && !any_nan;
                    res_d.flags[FLAG_INV] = any_nan;
                end
                OP_LE: begin
                    res_d.res_bool        = ord_le && !any_nan;
                    res_d.flags[FLAG_INV] = any_nan;
                end
                OP_LTQ: begin
                    res_d.res_bool        = ord_lt && !any_nan;
                    res_d.flags[FLAG_INV] = any_snan;
                end
                OP_LEQ: begin
                    res_d.res_bool        = ord_le && !any_nan;
                    res_d.flags[FLAG_INV] = any_snan;
                end
                OP_MIN, OP_MAX: begin
                    res_d.flags[FLAG_INV] = any_snan;
                    if (cls[0].is_nan && cls[1].is_nan)
                        res_d.res_val = CANON_NAN;
                    else if (cls[0].is_nan)
                        res_d.res_val = opnd_b;
                    else if (cls[1].is_nan)
                        res_d.res_val = opnd_a;
                    else if (cls[0].is_zero && cls[1].is_zero)
                        // negative zero wins for min, positive for max
                        res_d.res_val = ((op_e == OP_MIN) == opnd_a[W-1]) ? opnd_a : opnd_b;
                    else if (op_e == OP_MIN)
                        res_d.res_val = ord_lt ? opnd_a : opnd_b;
                    else
                        res_d.res_val = ord_lt ? opnd_b : opnd_a;
                end
                default: begin
                    res_d.res_bool = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_bool  = res_q.res_bool;
    assign out_val   = res_q.res_val;
    assign out_flags = res_q.flags;

    assert_flags_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[FLAG_INV-1:0] == '0);

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_val) && $stable(out_bool) && $stable(out_flags)));

    assert_cmp_nan_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 3'd4 && any_nan) |=> !out_bool);

    assert_minmax_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd5 || op == 3'd6)) |=>
        (out_val == $past(opnd_a) || out_val == $past(opnd_b) || out_val == CANON_NAN));

    assert_minmax_bool_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 3'd5) |=> !out_bool);

    assert_cmp_val_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 3'd4) |=> out_val == '0);

endmodule

// File: tb/tb_fpcmp_unit.sv
module tb_fpcmp_unit;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        exp_bool;
        logic [31:0] exp_val;
        logic [4:0]  exp_flags;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam logic [4:0] NV_F = 5'h10;

    localparam vec_t VEC [NV] = '{
        // R2 equal
        '{3'd0, 32'h3F800000, 32'h3F800000, 1'b1, 32'h0, 5'h00, 4'd2},
        '{3'd0, 32'h00000000, 32'h80000000, 1'b1, 32'h0, 5'h00, 4'd6},
        '{3'd0, 32'h3F800000, 32'h40000000, 1'b0, 32'h0, 5'h00, 4'd2},
        '{3'd0, 32'h7FC00000, 32'h7FC00000, 1'b0, 32'h0, 5'h00, 4'd2},
        '{3'd0, 32'h7F800001, 32'h3F800000, 1'b0, 32'h0, NV_F,  4'd2},
        // R5 ordering, R3 signaling less-than
        '{3'd1, 32'h3F800000, 32'h40000000, 1'b1, 32'h0, 5'h00, 4'd5},
        '{3'd1, 32'hC0000000, 32'hBF800000, 1'b1, 32'h0, 5'h00, 4'd5},
        '{3'd1, 32'hBF800000, 32'hC0000000, 1'b0, 32'h0, 5'h00, 4'd5},
        '{3'd1, 32'hBF800000, 32'h00000001, 1'b1, 32'h0, 5'h00, 4'd5},
        '{3'd1, 32'h80000000, 32'h00000000, 1'b0, 32'h0, 5'h00, 4'd6},
        '{3'd1, 32'h7FC00000, 32'h3F800000, 1'b0, 32'h0, NV_F,  4'd3},
        '{3'd1, 32'hFF800000, 32'h7F800000, 1'b1, 32'h0, 5'h00, 4'd5},
        // R5 / R6 / R3 less-or-equal
        '{3'd2, 32'h3F800000, 32'h3F800000, 1'b1, 32'h0, 5'h00, 4'd5},
        '{3'd2, 32'h00000000, 32'h80000000, 1'b1, 32'h0, 5'h00, 4'd6},
        '{3'd2, 32'h40000000, 32'h3F800000, 1'b0, 32'h0, 5'h00, 4'd5},
        '{3'd2, 32'h3F800000, 32'hFFC00001, 1'b0, 32'h0, NV_F,  4'd3},
        // R4 quiet compares
        '{3'd3, 32'h7FC00000, 32'h3F800000, 1'b0, 32'h0, 5'h00, 4'd4},
        '{3'd3, 32'h7F800001, 32'h3F800000, 1'b0, 32'h0, NV_F,  4'd4},
        '{3'd4, 32'h3F800000, 32'h7FC00000, 1'b0, 32'h0, 5'h00, 4'd4},
        '{3'd4, 32'hBF800000, 32'h3F800000, 1'b1, 32'h0, 5'h00, 4'd4},
        // R7 / R8 / R9 min
        '{3'd5, 32'h3F800000, 32'h40000000, 1'b0, 32'h3F800000, 5'h00, 4'd7},
        '{3'd5, 32'h7FC00000, 32'h40000000, 1'b0, 32'h40000000, 5'h00, 4'd7},
        '{3'd5, 32'h7F800001, 32'h7FC00000, 1'b0, 32'h7FC00000, NV_F,  4'd9},
        '{3'd5, 32'h00000000, 32'h80000000, 1'b0, 32'h80000000, 5'h00, 4'd8},
        '{3'd5, 32'h80000000, 32'h00000000, 1'b0, 32'h80000000, 5'h00, 4'd8},
        '{3'd5, 32'hC0000000, 32'hBF800000, 1'b0, 32'hC0000000, 5'h00, 4'd7},
        // R7 / R8 / R9 max
        '{3'd6, 32'h80000000, 32'h00000000, 1'b0, 32'h00000000, 5'h00, 4'd8},
        '{3'd6, 32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 5'h00, 4'd8},
        '{3'd6, 32'h3F800000, 32'hFFC00001, 1'b0, 32'h3F800000, 5'h00, 4'd7},
        '{3'd6, 32'hFFC00001, 32'h7F800001, 1'b0, 32'h7FC00000, NV_F,  4'd9},
        '{3'd6, 32'hBF800000, 32'h3FC00000, 1'b0, 32'h3FC00000, 5'h00, 4'd7},
        // R12 reserved code
        '{3'd7, 32'h3F800000, 32'h3F800000, 1'b0, 32'h0, 5'h00, 4'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic        out_bool;
    logic [31:0] out_val;
    logic [4:0]  out_flags;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fpcmp_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .out_bool  (out_bool),
        .out_val   (out_val),
        .out_flags (out_flags)
    );

    task automatic check(input string tag, input logic v, input logic bo,
                         input logic [31:0] va, input logic [4:0] fl);
        tests++;
        if (out_valid !== v || out_bool !== bo || out_val !== va || out_flags !== fl) begin
            fails++;
            $display("FAIL %s: got valid=%b bool=%b val=%h flags=%h, expected valid=%b bool=%b val=%h flags=%h",
                     tag, out_valid, out_bool, out_val, out_flags, v, bo, va, fl);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        op       = o;
        opnd_a   = a;
        opnd_b   = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", 1'b0, 1'b0, 32'h0, 5'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].a, VEC[i].b);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), 1'b1,
                  VEC[i].exp_bool, VEC[i].exp_val, VEC[i].exp_flags);
        end

        // R10: pulse drops and result holds while inputs change with in_valid low
        apply(3'd5, 32'h7F800001, 32'hBF800000);
        check("R9 min snan", 1'b1, 1'b0, 32'hBF800000, NV_F);
        op = 3'd0; opnd_a = 32'h3F800000; opnd_b = 32'h3F800000;
        @(negedge clk);
        check("R10 hold 1", 1'b0, 1'b0, 32'hBF800000, NV_F);
        @(negedge clk);
        check("R10 hold 2", 1'b0, 1'b0, 32'hBF800000, NV_F);

        // R10: back-to-back valid inputs each produce a result one cycle later
        @(negedge clk);
        in_valid = 1'b1; op = 3'd1; opnd_a = 32'h3F800000; opnd_b = 32'h40000000;
        @(negedge clk);
        check("R10 b2b first", 1'b1, 1'b1, 32'h0, 5'h0);
        op = 3'd6; opnd_a = 32'hC0000000; opnd_b = 32'h80000000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 b2b second", 1'b1, 1'b0, 32'h80000000, 5'h0);

        // R11: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset again", 1'b0, 1'b0, 32'h0, 5'h0);
        rst_n = 1'b1;
        apply(3'd4, 32'h80000000, 32'h00000000);
        check("R6 quiet le zeros", 1'b1, 1'b1, 32'h0, 5'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule